// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

A behavioural, synthesizable single-port synchronous SRAM. Any mix of reads and writes can be issued on consecutive clocks without idle cycles. Each accepted command moves through two address register stages. A read drives its word from the following edge. A write takes its data from the bus at the second edge after its address and commits it to the array at that edge.

When a read directly follows a write to the same word, the read gets the incoming write data through a forwarding path. The forwarding is merged per byte lane with the array contents. The host sees each word as four 9-bit lanes. The block also provides:

- a two-bit burst counter with linear or interleaved ordering;
- three chip enables;
- a global clock enable that freezes the whole pipeline;
- an asynchronous output enable;
- a sleep input that blocks new commands.

The bidirectional data bus is modelled as a separate input, output and drive-enable.

Top module: `nbt_sram`

## Requirements
- R1: A read accepted at rising edge n, with clkEn high at edges n and n+1, puts the addressed word on dataOut at edge n+1. With oeN low and sleep low, dataOe is then high until the next enabled edge.
- R2: A write accepted at edge n samples dataIn at edge n+2, the second enabled edge after n. byteWrN is active low and is sampled with the address. When byteWrN[i] is 0, bits [9i+8:9i] are updated; the other bits keep their value.
- R3: Reads and writes issued on every enabled edge, in any order, each return or store the correct data with no idle cycles between them.
- R4: A read issued on the enabled edge directly after a write to the same address returns the new write data in the written lanes and the old contents in the others.
- R5: An edge with clkEn low changes no state. dataOut and dataOe hold, and neither pending writes nor burst position advance.
- R6: A load (advance low) is selected only when ce1N=0, ce2=1 and ce3N=0. An unselected load issues no operation: nothing is written and dataOe stays low for its data phase.
- R7: dataOe is low during the data phase of a write and of an idle cycle.
- R8: With advance=1, the previous command type continues at the next burst address. The burst count starts at 0 on a load and counts up by 1 on each advance. The two low address bits are base+count mod 4 when interleave=0, and base XOR count when interleave=1. The upper address bits do not change. An advance after an idle cycle is idle, and on an advance weN and the chip enables are ignored.
- R9: oeN high forces dataOe low at once, without a clock edge and without changing dataOut.
- R10: While sleep is high, any command sampled is treated as idle and dataOe is low.
- R11: While rstN is low, the pipeline is idle and dataOe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset of pipeline state |
| clkEn | input | 1 | Clock enable; low freezes all state |
| addrIn | input | ADDR_W | Word address for a load |
| advance | input | 1 | 1 = advance burst, 0 = load new command |
| weN | input | 1 | Active-low write enable (loads only) |
| byteWrN | input | 4 | Active-low per-lane write selects |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| oeN | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Blocks new commands and turns off outputs |
| dataIn | input | 36 | Write data from the bus |
| dataOut | output | 36 | Read data to the bus |
| dataOe | output | 1 | Bus drive enable |

## Verification
The interesting collision is a posted write committing in the same cycle as the array lookup for a read of the same word. The read must return the write's bus data in the masked lanes and the stored data elsewhere. This is provoked by a directed write-then-read pair with a partial lane mask. Random traffic confined to sixteen addresses, with frequent bursts, makes write-read pairs hit the same word often. Every read result is compared against a bench model that applies each write before serving any later read, independent of how the design forwards.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } opKind_t;

  // Strobes from control to datapath for the current cycle
  typedef struct packed {
    logic             step;    // enabled edge ahead
    logic             rdEn;    // stage 1 holds a read: load output register
    logic             wrEn;    // stage 2 holds a write: commit dataIn
    logic [LANES-1:0] wrMask;  // active-high lane mask of that write
  } strobe_t;
endpackage

// File: rtl/nbt_ctrl.sv
module nbt_ctrl
  import nbt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              advance,
  input  logic              weN,
  input  logic [LANES-1:0]  byteWrN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              interleave,
  input  logic              sleep,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr
);
  localparam int CNT_W = 2;

  opKind_t             s1Op, s2Op, nOp;
  logic [ADDR_W-1:0]   s1Addr, s2Addr, nAddr;
  logic [LANES-1:0]    s1Mask, s2Mask, nMask;
  logic [CNT_W-1:0]    baseLow, burstCnt, nBase, nCnt, cntNext, burstLow;
  logic                selected;

  assign selected = !ce1N && ce2 && !ce3N;
  assign cntNext  = burstCnt + 2'd1;
  assign burstLow = interleave ? (baseLow ^ cntNext) : (baseLow + cntNext);

  // Next command for stage 1
  always_comb begin
    nOp   = OP_IDLE;
    nAddr = s1Addr;
    nMask = ~byteWrN;
    nBase = baseLow;
    nCnt  = burstCnt;
    if (sleep) begin
      nOp = OP_IDLE;
    end else if (advance) begin
      nOp   = s1Op;
      nAddr = {s1Addr[ADDR_W-1:CNT_W], burstLow};
      nCnt  = cntNext;
    end else begin
      nOp   = selected ? (weN ? OP_READ : OP_WRITE) : OP_IDLE;
      nAddr = addrIn;
      nBase = addrIn[CNT_W-1:0];
      nCnt  = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Op     <= OP_IDLE;
      s2Op     <= OP_IDLE;
      s1Addr   <= '0;
      s2Addr   <= '0;
      s1Mask   <= '0;
      s2Mask   <= '0;
      baseLow  <= '0;
      burstCnt <= '0;
    end else if (clkEn) begin
      s1Op     <= nOp;
      s1Addr   <= nAddr;
      s1Mask   <= nMask;
      baseLow  <= nBase;
      burstCnt <= nCnt;
      s2Op     <= s1Op;
      s2Addr   <= s1Addr;
      s2Mask   <= s1Mask;
    end
  end

  always_comb begin
    stb.step   = clkEn;
    stb.rdEn   = (s1Op == OP_READ);
    stb.wrEn   = (s2Op == OP_WRITE);
    stb.wrMask = s2Mask;
  end
  assign rdAddr = s1Addr;
  assign wrAddr = s2Addr;

  assert_deselect_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    clkEn && !advance && !sleep && !(!ce1N && ce2 && !ce3N) |=> s1Op == OP_IDLE);

  assert_burst_upper_R8: assert property (@(posedge clk) disable iff (!rstN)
    clkEn && advance && !sleep |=> s1Addr[ADDR_W-1:CNT_W] == $past(s1Addr[ADDR_W-1:CNT_W]));

  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(s1Op) && $stable(s1Addr) && $stable(s2Op) && $stable(burstCnt));

  assert_sleep_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    clkEn && sleep |=> s1Op == OP_IDLE);

  assert_write_stage_R2: assert property (@(posedge clk) disable iff (!rstN)
    clkEn && s1Op == OP_WRITE |=> s2Op == OP_WRITE && s2Addr == $past(s1Addr));
endmodule

// File: rtl/nbt_data.sv
module nbt_data
  import nbt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              oeN,
  input  logic              sleep,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataOe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] arrWord, oldWord, wrWord, fwdWord, outData;
  logic              fwdHit, outVld;

  assign arrWord = mem[rdAddr];
  assign oldWord = mem[wrAddr];
  assign fwdHit  = stb.wrEn && (wrAddr == rdAddr);

  // Per-lane merge for the array write and the read forward path
  for (genvar l = 0; l < LANES; l++) begin : gLane
    assign wrWord[l*LANE_W +: LANE_W] =
      stb.wrMask[l] ? dataIn[l*LANE_W +: LANE_W] : oldWord[l*LANE_W +: LANE_W];
    assign fwdWord[l*LANE_W +: LANE_W] =
      (fwdHit && stb.wrMask[l]) ? dataIn[l*LANE_W +: LANE_W] : arrWord[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (stb.step && stb.wrEn) mem[wrAddr] <= wrWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outVld  <= 1'b0;
      outData <= '0;
    end else if (stb.step) begin
      outVld <= stb.rdEn;
      if (stb.rdEn) outData <= fwdWord;
    end
  end

  assign dataOut = outData;
  assign dataOe  = outVld && !oeN && !sleep;

  assert_read_drive_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.step && stb.rdEn |=> outVld && dataOut == $past(fwdWord));

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.step |=> $stable(dataOut) && $stable(outVld));

  assert_write_phase_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> !dataOe);

  assert_forward_lane_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.step && stb.rdEn && fwdHit && stb.wrMask[0] |=> dataOut[LANE_W-1:0] == $past(dataIn[LANE_W-1:0]));
endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
  import nbt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              advance,
  input  logic              weN,
  input  logic [3:0]        byteWrN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              interleave,
  input  logic              oeN,
  input  logic              sleep,
  input  logic [35:0]       dataIn,
  output logic [35:0]       dataOut,
  output logic              dataOe
);
  strobe_t           stb;
  logic [ADDR_W-1:0] rdAddr, wrAddr;

  nbt_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .addrIn(addrIn), .advance(advance),
    .weN(weN), .byteWrN(byteWrN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .interleave(interleave), .sleep(sleep), .stb(stb), .rdAddr(rdAddr), .wrAddr(wrAddr)
  );

  nbt_data #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .dataIn(dataIn), .oeN(oeN), .sleep(sleep), .dataOut(dataOut), .dataOe(dataOe)
  );

  assert_reset_quiet_R11: assert property (@(posedge clk) !rstN |=> !dataOe);
endmodule

// File: tb/sim_nbt_sram.sv
module sim_nbt_sram;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN, clkEn, advance, weN, ce1N, ce2, ce3N, interleave, oeN, sleep;
  logic [AW-1:0] addrIn;
  logic [3:0]    byteWrN;
  logic [35:0]   dataIn, dataOut;
  logic          dataOe;

  always #5 clk = ~clk;

  nbt_sram #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .addrIn(addrIn), .advance(advance),
    .weN(weN), .byteWrN(byteWrN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .interleave(interleave), .oeN(oeN), .sleep(sleep), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string curTag = "R11";

  // Reference model: ops 0 idle, 1 read, 2 write
  logic [35:0] mdl [DEPTH];
  int          p1Op, p2Op, p1Addr, p2Addr, bBase, bCnt;
  logic [3:0]  p1Mask, p2Mask;
  logic [35:0] expOut;
  bit          expVld;

  task automatic chk(bit ok, string what, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", curTag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    p1Op = 0; p2Op = 0; p1Addr = 0; p2Addr = 0; bBase = 0; bCnt = 0;
    p1Mask = 0; p2Mask = 0; expVld = 0; expOut = '0;
  endtask

  task automatic modelEdge();
    if (!clkEn) return;
    if (p2Op == 2)
      for (int l = 0; l < 4; l++)
        if (p2Mask[l]) mdl[p2Addr][l*9 +: 9] = dataIn[l*9 +: 9];
    expVld = (p1Op == 1);
    if (expVld) expOut = mdl[p1Addr];
    p2Op = p1Op; p2Addr = p1Addr; p2Mask = p1Mask;
    if (sleep) begin
      p1Op = 0;
    end else if (advance) begin
      bCnt = (bCnt + 1) % 4;
      p1Addr = (p1Addr & ~3) | (interleave ? (bBase ^ bCnt) : ((bBase + bCnt) % 4));
    end else begin
      p1Op   = (!ce1N && ce2 && !ce3N) ? (weN ? 1 : 2) : 0;
      p1Addr = int'(addrIn);
      bBase  = int'(addrIn) % 4;
      bCnt   = 0;
    end
    p1Mask = ~byteWrN;
  endtask

  task automatic checkOut();
    bit expOe;
    expOe = expVld && !oeN && !sleep;
    chk(dataOe === expOe, "dataOe", {35'd0, dataOe}, {35'd0, expOe});
    if (expVld) chk(dataOut === expOut, "dataOut", dataOut, expOut);
  endtask

  task automatic tick();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    checkOut();
  endtask

  task automatic cmd(bit en, bit adv, bit wN, logic [3:0] bwN, bit sel, int a);
    clkEn = en; advance = adv; weN = wN; byteWrN = bwN;
    ce1N = !sel; ce2 = 1'b1; ce3N = 1'b0;
    addrIn = AW'(a);
    dataIn = {$urandom(), $urandom()};
    tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cmd(1, 0, 1, 4'hF, 0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R3 watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; clkEn = 1; advance = 0; weN = 1; byteWrN = 4'hF; ce1N = 1; ce2 = 1;
    ce3N = 0; interleave = 0; oeN = 0; sleep = 0; addrIn = '0; dataIn = '0;
    modelReset();
    @(negedge clk); @(negedge clk);
    curTag = "R11";
    chk(dataOe === 1'b0, "reset dataOe", {35'd0, dataOe}, 36'd0);
    rstN = 1;

    // R3: fill whole array back-to-back, then read some back
    curTag = "R3";
    for (int a = 0; a < DEPTH; a++) cmd(1, 0, 0, 4'h0, 1, a);
    idle(2);
    for (int a = 0; a < 8; a++) cmd(1, 0, a % 2, 4'h0, 1, a);
    idle(2);

    // R2: partial lane writes then read
    curTag = "R2";
    cmd(1, 0, 0, 4'b1010, 1, 20);
    cmd(1, 0, 0, 4'b0111, 1, 21);
    idle(2);
    cmd(1, 0, 1, 4'hF, 1, 20);
    cmd(1, 0, 1, 4'hF, 1, 21);
    idle(2);

    // R4: read right behind a write to the same word
    curTag = "R4";
    cmd(1, 0, 0, 4'b1010, 1, 30);
    cmd(1, 0, 1, 4'hF, 1, 30);
    cmd(1, 0, 0, 4'b0000, 1, 31);
    cmd(1, 0, 1, 4'hF, 1, 31);
    idle(3);

    // R7: alternate read and write, drivers off in write data phases
    curTag = "R7";
    for (int i = 0; i < 8; i++) cmd(1, 0, i % 2, 4'h0, 1, 40 + i);
    idle(2);

    // R5: clock enable low freezes pipeline and outputs
    curTag = "R5";
    cmd(1, 0, 0, 4'h0, 1, 50);
    cmd(1, 0, 1, 4'hF, 1, 51);
    for (int i = 0; i < 3; i++) cmd(0, 0, 0, 4'h0, 1, 52);
    idle(3);
    cmd(1, 0, 1, 4'hF, 1, 50);
    idle(2);

    // R6: each chip enable deselects on its own
    curTag = "R6";
    clkEn = 1; advance = 0; weN = 0; byteWrN = 4'h0; addrIn = 8'd60;
    ce1N = 1; ce2 = 1; ce3N = 0; dataIn = {$urandom(), $urandom()}; tick();
    ce1N = 0; ce2 = 0; ce3N = 0; dataIn = {$urandom(), $urandom()}; tick();
    ce1N = 0; ce2 = 1; ce3N = 1; weN = 1; dataIn = {$urandom(), $urandom()}; tick();
    idle(2);
    cmd(1, 0, 1, 4'hF, 1, 60);
    idle(2);

    // R8: linear and interleaved bursts from base 2
    curTag = "R8";
    interleave = 0;
    cmd(1, 0, 0, 4'h0, 1, 70);
    for (int i = 0; i < 3; i++) cmd(1, 1, 1, 4'h0, 0, 0);
    cmd(1, 0, 1, 4'hF, 1, 70);
    for (int i = 0; i < 3; i++) cmd(1, 1, 0, 4'hF, 0, 0);
    interleave = 1;
    cmd(1, 0, 1, 4'hF, 1, 74);
    for (int i = 0; i < 3; i++) cmd(1, 1, 0, 4'hF, 0, 0);
    cmd(1, 0, 1, 4'hF, 0, 0);
    cmd(1, 1, 1, 4'hF, 1, 0);
    idle(2);
    interleave = 0;

    // R9: asynchronous output disable during a read data phase
    curTag = "R9";
    cmd(1, 0, 1, 4'hF, 1, 70);
    cmd(1, 0, 1, 4'hF, 0, 0);
    oeN = 1; #1;
    chk(dataOe === 1'b0, "async oe", {35'd0, dataOe}, 36'd0);
    chk(dataOut === expOut, "dataOut under oe", dataOut, expOut);
    oeN = 0; #1;
    chk(dataOe === 1'b1, "oe restored", {35'd0, dataOe}, 36'd1);
    idle(2);

    // R10: sleep ignores loads and advances
    curTag = "R10";
    sleep = 1;
    cmd(1, 0, 0, 4'h0, 1, 80);
    cmd(1, 0, 1, 4'hF, 1, 80);
    cmd(1, 1, 1, 4'hF, 1, 0);
    sleep = 0;
    idle(2);
    cmd(1, 0, 1, 4'hF, 1, 80);
    idle(2);

    // R1 and R3: constrained random mix on 16 addresses
    for (int i = 0; i < 4000; i++) begin
      curTag = (i % 2 == 0) ? "R1" : "R3";
      interleave = 1'($urandom_range(0, 1));
      sleep      = ($urandom_range(0, 99) < 3);
      oeN        = ($urandom_range(0, 99) < 8);
      cmd(($urandom_range(0, 99) < 90), ($urandom_range(0, 99) < 30),
          1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)),
          ($urandom_range(0, 99) < 88), $urandom_range(0, 15));
    end
    sleep = 0; oeN = 0;
    idle(3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule